// File: doc/BRIEF.md
# Linear Photodiode Sensor Readout Controller

This block sits on the host side of a two-chip linear photodiode sensor. It derives the sensor clock from the system clock and shapes the reset pulse whose high time is the integration window. Each reset edge is placed on a falling edge of the sensor clock. The low phase is held long enough that the reset rise never lands inside the video readout and that one full reset cycle never falls below the pixel-count-dependent minimum. Both timing fields come from configuration inputs. Values outside the legal range are clamped and recorded in a sticky error flag.

The sensor raises a trigger pulse for every pixel it puts on its video line. On each trigger the controller captures the matching ADC word, tags it with a channel number and presents it on a valid/ready stream. In serial mode the two chips are chained: the second chip starts from the first chip's end-of-scan, and all pixels arrive on stream A in order. In parallel mode both chips run as masters, and stream A and stream B each carry one chip's half of the line at the same time. A one-cycle frame-done pulse marks the end of a scan.

Inputs from the sensor and the ADC are assumed to be already synchronous to `clk`.

Top module: `linesense_ctrl`

## Requirements
- R1: While `rst_n` is low, `sclk` is 0. Each high phase and each low phase of `sclk` lasts H system cycles, where H is `cfg_half` clamped to the range [HALF_MIN, HALF_MAX].
- R2: `sreset` changes value only in the system cycle in which `sclk` falls.
- R3: `sreset` is 1 out of reset. Each high phase lasts I falls of `sclk`, where I is `cfg_integ` clamped to the range [1, INTEG_MAX].
- R4: Each low phase of `sreset` lasts MIN_PERIOD − I falls of `sclk`, but never fewer than VIDEO_WIN falls. NPIX is 2·CHIP_PIX, MIN_PERIOD is ⌈20.5·NPIX⌉ and VIDEO_WIN is 4·NPIX+20.
- R5: `cfg_err` is 0 after reset. It goes to 1 when either configuration field is outside its range, and stays at 1 until the next reset.
- R6: In serial mode (`cfg_par`=0), a rising edge of `trig_a` OR `trig_b` captures `adc_a` onto stream A. Channel numbers run 0, 1, 2 … and restart at 0 on every fall of `sreset`. Stream B stays idle.
- R7: In parallel mode (`cfg_par`=1), a rising edge of `trig_a` captures `adc_a` onto stream A with channels from 0. A rising edge of `trig_b` captures `adc_b` onto stream B with channels from CHIP_PIX. Both streams can load in the same cycle.
- R8: The valid signal of a stream rises in the cycle after the trigger rise. It then holds, with data and channel unchanged, until a cycle in which ready is 1.
- R9: A trigger that arrives while its stream holds an unaccepted sample is dropped, but still advances the channel count. It sets the sticky flag `overrun`, which is 0 after reset.
- R10: `frame_done` is a one-cycle pulse in the cycle after a detected falling edge on an end-of-scan input. In serial mode it follows a fall of `eos_b_n`. In parallel mode it follows the later of the falls of `eos_a_n` and `eos_b_n` since the last frame start.
- R11: `chip_b_master` equals `cfg_par`. `chip_b_start` follows `eos_a_n` in serial mode and is 1 in parallel mode.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_par | input | 1 | 1 = two chips in parallel, 0 = chained |
| cfg_half | input | HALF_W | Sensor clock half period in system cycles |
| cfg_integ | input | INTEG_W | Integration time in sensor clock falls |
| sclk | output | 1 | Sensor clock |
| sreset | output | 1 | Sensor reset / integration pulse |
| chip_b_start | output | 1 | Start input for the second chip |
| chip_b_master | output | 1 | Master select for the second chip |
| trig_a | input | 1 | Pixel trigger from the first chip |
| trig_b | input | 1 | Pixel trigger from the second chip |
| adc_a | input | DATA_W | ADC word for the first (or shared) video line |
| adc_b | input | DATA_W | ADC word for the second video line |
| eos_a_n | input | 1 | End of scan from the first chip, active low |
| eos_b_n | input | 1 | End of scan from the second chip, active low |
| a_valid | output | 1 | Stream A sample valid |
| a_ready | input | 1 | Stream A sample accepted |
| a_data | output | DATA_W | Stream A pixel value |
| a_chan | output | CH_W | Stream A channel number |
| b_valid | output | 1 | Stream B sample valid |
| b_ready | input | 1 | Stream B sample accepted |
| b_data | output | DATA_W | Stream B pixel value |
| b_chan | output | CH_W | Stream B channel number |
| frame_done | output | 1 | One-cycle end-of-frame pulse |
| cfg_err | output | 1 | Sticky: a configuration field was clamped |
| overrun | output | 1 | Sticky: a sample was dropped |

## Verification
The bench measures every reset phase in sensor clock falls for in-range, below-range and above-range integration settings. These cover both branches of the low-phase rule. A swapped branch or a missing clamp shows up as a run length that is off by tens of falls. The sensor clock is measured at both clamp limits, and any reset edge that is not on a clock fall is counted as an error. Channel numbering is followed across the chip boundary in serial mode, through a frame restart, and with the offset base in parallel mode. A dropped sample must keep the held word, and the frame-done pulse must wait for both end-of-scan falls in either order in parallel mode.

// File: rtl/slc_pkg.sv
// Shared definitions for the linear sensor readout controller.
package slc_pkg;
    // Level of the sensor reset pulse; high is the integration window.
    typedef enum logic {
        PH_LOW  = 1'b0,
        PH_HIGH = 1'b1
    } phase_t;
endpackage

// File: rtl/slc_clkgen.sv
// Sensor clock generator.
// Divides clk so that each sclk phase lasts 'half' cycles and flags the
// cycle in which sclk falls. Assumes half >= 1 (the top clamps it).
module slc_clkgen #(
    parameter int HALF_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [HALF_W-1:0] half,
    output logic              sclk,
    output logic              fall_evt
);
    logic [HALF_W-1:0] hc;
    logic              toggle;

    // Phase end: the counter has reached (or passed, after a change) half-1.
    always_comb begin
        toggle   = (hc >= half - HALF_W'(1));
        fall_evt = toggle && sclk;
    end

    // Phase counter and clock output register.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            hc   <= '0;
            sclk <= 1'b0;
        end else if (toggle) begin
            hc   <= '0;
            sclk <= ~sclk;
        end else begin
            hc <= hc + HALF_W'(1);
        end
    end
endmodule

// File: rtl/slc_frame_seq.sv
// Reset pulse sequencer.
// Counts sensor clock falls and switches the reset level after high_len
// falls (high) or low_len falls (low); every switch is on a fall event.
// Assumes both lengths are >= 1.
module slc_frame_seq
    import slc_pkg::*;
#(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             fall_evt,
    input  logic [CNT_W-1:0] high_len,
    input  logic [CNT_W-1:0] low_len,
    output logic             sreset,
    output logic             frame_start
);
    phase_t           phase;
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cur_len;
    logic             last;

    // Length of the current phase and whether this fall ends it.
    always_comb begin
        cur_len     = (phase == PH_HIGH) ? high_len : low_len;
        last        = fall_evt && (cnt >= cur_len - CNT_W'(1));
        frame_start = last && (phase == PH_HIGH);
        sreset      = (phase == PH_HIGH);
    end

    // Phase and fall counter update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_HIGH;
            cnt   <= '0;
        end else if (last) begin
            phase <= (phase == PH_HIGH) ? PH_LOW : PH_HIGH;
            cnt   <= '0;
        end else if (fall_evt) begin
            cnt <= cnt + CNT_W'(1);
        end
    end
endmodule

// File: rtl/slc_lane.sv
// One capture lane.
// On a rising trigger, loads the ADC word and channel (base + index) into a
// one-entry valid/ready holding register. If that register is still full,
// the sample is dropped and a sticky overrun is set. The index restarts on
// frame_start. Assumes the inputs are synchronous to clk.
module slc_lane #(
    parameter int DATA_W = 12,
    parameter int CH_W   = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en,
    input  logic              trig,
    input  logic [DATA_W-1:0] sample,
    input  logic [CH_W-1:0]   base,
    input  logic              frame_start,
    input  logic              ready,
    output logic              valid,
    output logic [DATA_W-1:0] data,
    output logic [CH_W-1:0]   chan,
    output logic              overrun
);
    logic            trig_q;
    logic            rise;
    logic [CH_W-1:0] cnt;
    logic [CH_W-1:0] idx;

    // Trigger edge and the index this sample would use.
    always_comb begin
        rise = en && trig && !trig_q;
        idx  = frame_start ? '0 : cnt;
    end

    // Edge history, index counter, holding register and overrun flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            trig_q  <= 1'b0;
            cnt     <= '0;
            valid   <= 1'b0;
            data    <= '0;
            chan    <= '0;
            overrun <= 1'b0;
        end else begin
            trig_q <= trig;
            if (frame_start) cnt <= '0;
            if (valid && ready) valid <= 1'b0;
            if (rise) begin
                cnt <= idx + CH_W'(1);
                if (valid && !ready) begin
                    overrun <= 1'b1;
                end else begin
                    valid <= 1'b1;
                    data  <= sample;
                    chan  <= base + idx;
                end
            end
        end
    end
endmodule

// File: rtl/linesense_ctrl.sv
// Host-side readout controller for a two-chip linear photodiode sensor.
// Clamps the timing configuration, generates the sensor clock and reset
// pulse, captures pixel samples on two lanes, and detects end of frame.
// Assumes all sensor and ADC inputs are synchronous to clk.
module linesense_ctrl #(
    parameter int CHIP_PIX  = 128,
    parameter int DATA_W    = 12,
    parameter int HALF_W    = 16,
    parameter int HALF_MIN  = 13,
    parameter int HALF_MAX  = 1250,
    parameter int INTEG_W   = 20,
    parameter int INTEG_MAX = 1000000,
    localparam int CH_W     = $clog2(2 * CHIP_PIX)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_par,
    input  logic [HALF_W-1:0]  cfg_half,
    input  logic [INTEG_W-1:0] cfg_integ,
    output logic               sclk,
    output logic               sreset,
    output logic               chip_b_start,
    output logic               chip_b_master,
    input  logic               trig_a,
    input  logic               trig_b,
    input  logic [DATA_W-1:0]  adc_a,
    input  logic [DATA_W-1:0]  adc_b,
    input  logic               eos_a_n,
    input  logic               eos_b_n,
    output logic               a_valid,
    input  logic               a_ready,
    output logic [DATA_W-1:0]  a_data,
    output logic [CH_W-1:0]    a_chan,
    output logic               b_valid,
    input  logic               b_ready,
    output logic [DATA_W-1:0]  b_data,
    output logic [CH_W-1:0]    b_chan,
    output logic               frame_done,
    output logic               cfg_err,
    output logic               overrun
);
    localparam int NPIX       = 2 * CHIP_PIX;
    localparam int MIN_PERIOD = (41 * NPIX + 1) / 2;
    localparam int VIDEO_WIN  = 4 * NPIX + 20;
    localparam int NLANE      = 2;

    logic [HALF_W-1:0]  half_c;
    logic [INTEG_W-1:0] integ_c;
    logic [INTEG_W-1:0] low_len;
    logic [INTEG_W:0]   integ_plus_win;
    logic               half_bad, integ_bad;
    logic               fall_evt, frame_start;
    logic               eos_a_q, eos_b_q, fall_a, fall_b;
    logic               seen_a, seen_b, both_seen;

    logic              lane_en   [NLANE];
    logic              lane_trig [NLANE];
    logic [DATA_W-1:0] lane_smp  [NLANE];
    logic [CH_W-1:0]   lane_base [NLANE];
    logic              lane_rdy  [NLANE];
    logic              lane_vld  [NLANE];
    logic [DATA_W-1:0] lane_dat  [NLANE];
    logic [CH_W-1:0]   lane_chn  [NLANE];
    logic              lane_ovr  [NLANE];

    // Clamp the clock half period to the legal sensor clock range.
    always_comb begin
        half_bad = (cfg_half < HALF_W'(HALF_MIN)) || (cfg_half > HALF_W'(HALF_MAX));
        if (cfg_half < HALF_W'(HALF_MIN))      half_c = HALF_W'(HALF_MIN);
        else if (cfg_half > HALF_W'(HALF_MAX)) half_c = HALF_W'(HALF_MAX);
        else                                   half_c = cfg_half;
    end

    // Clamp integration; stretch the low phase for the readout window and the minimum period.
    always_comb begin
        integ_bad = (cfg_integ == '0) || (cfg_integ > INTEG_W'(INTEG_MAX));
        if (cfg_integ == '0)                     integ_c = INTEG_W'(1);
        else if (cfg_integ > INTEG_W'(INTEG_MAX)) integ_c = INTEG_W'(INTEG_MAX);
        else                                      integ_c = cfg_integ;
        integ_plus_win = {1'b0, integ_c} + (INTEG_W + 1)'(VIDEO_WIN);
        if (integ_plus_win >= (INTEG_W + 1)'(MIN_PERIOD)) low_len = INTEG_W'(VIDEO_WIN);
        else                                              low_len = INTEG_W'(MIN_PERIOD) - integ_c;
    end

    // Sticky record of any clamped configuration field.
    always_ff @(posedge clk) begin
        if (!rst_n)                    cfg_err <= 1'b0;
        else if (half_bad || integ_bad) cfg_err <= 1'b1;
    end

    slc_clkgen #(.HALF_W(HALF_W)) u_clkgen (
        .clk      (clk),
        .rst_n    (rst_n),
        .half     (half_c),
        .sclk     (sclk),
        .fall_evt (fall_evt)
    );

    slc_frame_seq #(.CNT_W(INTEG_W)) u_seq (
        .clk         (clk),
        .rst_n       (rst_n),
        .fall_evt    (fall_evt),
        .high_len    (integ_c),
        .low_len     (low_len),
        .sreset      (sreset),
        .frame_start (frame_start)
    );

    // Chip chaining: the second chip starts from the first chip's end of scan when chained.
    always_comb begin
        chip_b_master = cfg_par;
        chip_b_start  = cfg_par ? 1'b1 : eos_a_n;
    end

    // Lane routing: chained mode merges both triggers onto lane 0 with the shared video line.
    always_comb begin
        lane_en[0]   = 1'b1;
        lane_trig[0] = cfg_par ? trig_a : (trig_a || trig_b);
        lane_smp[0]  = adc_a;
        lane_base[0] = '0;
        lane_rdy[0]  = a_ready;
        lane_en[1]   = cfg_par;
        lane_trig[1] = trig_b;
        lane_smp[1]  = adc_b;
        lane_base[1] = CH_W'(CHIP_PIX);
        lane_rdy[1]  = b_ready;
    end

    for (genvar g = 0; g < NLANE; g++) begin : g_lane
        slc_lane #(.DATA_W(DATA_W), .CH_W(CH_W)) u_lane (
            .clk         (clk),
            .rst_n       (rst_n),
            .en          (lane_en[g]),
            .trig        (lane_trig[g]),
            .sample      (lane_smp[g]),
            .base        (lane_base[g]),
            .frame_start (frame_start),
            .ready       (lane_rdy[g]),
            .valid       (lane_vld[g]),
            .data        (lane_dat[g]),
            .chan        (lane_chn[g]),
            .overrun     (lane_ovr[g])
        );
    end

    // Stream outputs and the combined overrun flag.
    always_comb begin
        a_valid = lane_vld[0];
        a_data  = lane_dat[0];
        a_chan  = lane_chn[0];
        b_valid = lane_vld[1];
        b_data  = lane_dat[1];
        b_chan  = lane_chn[1];
        overrun = lane_ovr[0] || lane_ovr[1];
    end

    // End-of-scan falling edges and the both-seen condition.
    always_comb begin
        fall_a    = eos_a_q && !eos_a_n;
        fall_b    = eos_b_q && !eos_b_n;
        both_seen = (seen_a || fall_a) && (seen_b || fall_b);
    end

    // End-of-scan tracking and the frame-done pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eos_a_q    <= 1'b1;
            eos_b_q    <= 1'b1;
            seen_a     <= 1'b0;
            seen_b     <= 1'b0;
            frame_done <= 1'b0;
        end else begin
            eos_a_q    <= eos_a_n;
            eos_b_q    <= eos_b_n;
            frame_done <= cfg_par ? both_seen : fall_b;
            if (frame_start || (cfg_par && both_seen)) begin
                seen_a <= 1'b0;
                seen_b <= 1'b0;
            end else begin
                seen_a <= seen_a || fall_a;
                seen_b <= seen_b || fall_b;
            end
        end
    end
endmodule

// File: rtl/linesense_ctrl_chk.sv
// Protocol checker for linesense_ctrl, attached by bind below.
// Observes only ports of the top module.
module linesense_ctrl_chk #(
    parameter int HALF_MIN = 13,
    parameter int DATA_W   = 12,
    parameter int CH_W     = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              sclk,
    input logic              sreset,
    input logic              a_valid,
    input logic              a_ready,
    input logic [DATA_W-1:0] a_data,
    input logic [CH_W-1:0]   a_chan,
    input logic              b_valid,
    input logic              b_ready,
    input logic [DATA_W-1:0] b_data,
    input logic              frame_done,
    input logic              cfg_err,
    input logic              overrun
);
    logic        sclk_q;
    logic [31:0] run;

    // Length of the current sclk phase, and a check that it is never shorter than HALF_MIN.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sclk_q <= 1'b0;
            run    <= '0;
        end else begin
            sclk_q <= sclk;
            if (sclk != sclk_q) begin
                a_r1_min_phase: assert (run >= 32'(HALF_MIN))
                    else $error("sclk phase shorter than HALF_MIN");
                run <= 32'd1;
            end else begin
                run <= run + 32'd1;
            end
        end
    end

    a_r2_edge_on_fall: assert property (@(posedge clk) disable iff (!rst_n)
        (sreset != $past(sreset)) |-> ($past(sclk) && !sclk));

    a_r8_a_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (a_valid && !a_ready) |=> (a_valid && $stable(a_data) && $stable(a_chan)));

    a_r8_b_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (b_valid && !b_ready) |=> (b_valid && $stable(b_data)));

    a_r5_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_err |=> cfg_err);

    a_r9_ovr_sticky: assert property (@(posedge clk) disable iff (!rst_n)
        overrun |=> overrun);

    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        frame_done |=> !frame_done);
endmodule

bind linesense_ctrl linesense_ctrl_chk #(
    .HALF_MIN (HALF_MIN),
    .DATA_W   (DATA_W),
    .CH_W     (CH_W)
) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .sclk       (sclk),
    .sreset     (sreset),
    .a_valid    (a_valid),
    .a_ready    (a_ready),
    .a_data     (a_data),
    .a_chan     (a_chan),
    .b_valid    (b_valid),
    .b_ready    (b_ready),
    .b_data     (b_data),
    .frame_done (frame_done),
    .cfg_err    (cfg_err),
    .overrun    (overrun)
);

// File: tb/linesense_ctrl_bench.sv
// Bench for linesense_ctrl with a small configuration (4 pixels per chip).
module linesense_ctrl_bench;
    localparam int CHIP_PIX  = 4;
    localparam int DATA_W    = 12;
    localparam int HALF_W    = 8;
    localparam int HALF_MIN  = 2;
    localparam int HALF_MAX  = 6;
    localparam int INTEG_W   = 12;
    localparam int INTEG_MAX = 300;
    localparam int CH_W      = $clog2(2 * CHIP_PIX);
    localparam int NPIX      = 2 * CHIP_PIX;
    localparam int MINP      = (41 * NPIX + 1) / 2;
    localparam int VWIN      = 4 * NPIX + 20;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_par = 1'b0;
    logic [HALF_W-1:0] cfg_half = 8'd3;
    logic [INTEG_W-1:0] cfg_integ = 12'd10;
    logic trig_a = 1'b0, trig_b = 1'b0;
    logic [DATA_W-1:0] adc_a = '0, adc_b = '0;
    logic eos_a_n = 1'b1, eos_b_n = 1'b1;
    logic a_ready = 1'b0, b_ready = 1'b0;
    logic sclk, sreset, chip_b_start, chip_b_master;
    logic a_valid, b_valid, frame_done, cfg_err, overrun;
    logic [DATA_W-1:0] a_data, b_data;
    logic [CH_W-1:0] a_chan, b_chan;

    int checks = 0;
    int fails = 0;

    always #5 clk = ~clk;

    linesense_ctrl #(
        .CHIP_PIX(CHIP_PIX), .DATA_W(DATA_W), .HALF_W(HALF_W), .HALF_MIN(HALF_MIN),
        .HALF_MAX(HALF_MAX), .INTEG_W(INTEG_W), .INTEG_MAX(INTEG_MAX)
    ) u_linesense_ctrl (
        .clk(clk), .rst_n(rst_n), .cfg_par(cfg_par), .cfg_half(cfg_half),
        .cfg_integ(cfg_integ), .sclk(sclk), .sreset(sreset),
        .chip_b_start(chip_b_start), .chip_b_master(chip_b_master),
        .trig_a(trig_a), .trig_b(trig_b), .adc_a(adc_a), .adc_b(adc_b),
        .eos_a_n(eos_a_n), .eos_b_n(eos_b_n),
        .a_valid(a_valid), .a_ready(a_ready), .a_data(a_data), .a_chan(a_chan),
        .b_valid(b_valid), .b_ready(b_ready), .b_data(b_data), .b_chan(b_chan),
        .frame_done(frame_done), .cfg_err(cfg_err), .overrun(overrun)
    );

    // Waveform monitor: phase lengths of sclk and sreset, and misplaced reset edges.
    int run = 0, last_half = 0, n_sclk_ev = 0;
    int fcnt = 0, last_high = 0, last_low = 0, n_fall_ev = 0, n_rise_ev = 0;
    int r2_bad = 0;
    logic p_sclk = 1'b0, p_srst = 1'b1;
    always @(negedge clk) begin
        if (!rst_n) begin
            run = 0; fcnt = 0; p_sclk = 1'b0; p_srst = 1'b1;
        end else begin
            if (sclk != p_sclk) begin
                last_half = run; run = 1; n_sclk_ev++;
            end else begin
                run++;
            end
            if (sreset != p_srst) begin
                if (!(p_sclk && !sclk)) r2_bad++;
                if (p_srst) begin last_high = fcnt + 1; n_fall_ev++; end
                else        begin last_low  = fcnt + 1; n_rise_ev++; end
                fcnt = 0;
            end else if (p_sclk && !sclk) begin
                fcnt++;
            end
            p_sclk = sclk; p_srst = sreset;
        end
    end

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic finish_run();
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    function automatic int exp_low(input int integ);
        return (integ + VWIN >= MINP) ? VWIN : MINP - integ;
    endfunction

    task automatic do_reset();
        @(negedge clk); rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wait_fall();
        int k = n_fall_ev;
        while (n_fall_ev == k) @(negedge clk);
    endtask

    task automatic wait_rise();
        int k = n_rise_ev;
        while (n_rise_ev == k) @(negedge clk);
    endtask

    task automatic measure_half(input string req, input int exp);
        int k = n_sclk_ev;
        while (n_sclk_ev < k + 3) @(negedge clk);
        check(req, last_half, exp);
    endtask

    task automatic measure_reset(input int integ);
        wait_fall(); wait_fall();
        check("R3 high phase", last_high, integ);
        wait_rise();
        check("R4 low phase", last_low, exp_low(integ));
    endtask

    // One-cycle trigger pulse; the sample is visible at the following negedge.
    task automatic pulse_trig(input logic ta, input logic tb);
        @(negedge clk); trig_a = ta; trig_b = tb;
        @(negedge clk); trig_a = 1'b0; trig_b = 1'b0;
    endtask

    task automatic accept_both();
        a_ready = 1'b1; b_ready = 1'b1;
        @(negedge clk); a_ready = 1'b0; b_ready = 1'b0;
    endtask

    // One-cycle end-of-scan pulse and the frame-done value expected after it.
    task automatic pulse_eos(input logic ea, input logic eb, input int exp, input string req);
        @(negedge clk); eos_a_n = ~ea; eos_b_n = ~eb;
        @(negedge clk); eos_a_n = 1'b1; eos_b_n = 1'b1;
        check(req, int'(frame_done), exp);
        @(negedge clk);
        check("R10 pulse ends", int'(frame_done), 0);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        fails++; checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        // Reset state
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check("R1 sclk after reset", int'(sclk), 0);
        check("R3 sreset after reset", int'(sreset), 1);
        check("R8 no valid after reset", int'(a_valid | b_valid), 0);
        check("R5 err after reset", int'(cfg_err), 0);
        check("R9 overrun after reset", int'(overrun), 0);
        check("R11 master in serial", int'(chip_b_master), 0);

        // Legal timing settings
        measure_reset(10);
        measure_half("R1 half 3", 3);
        check("R5 legal config", int'(cfg_err), 0);
        cfg_half = 8'd5;
        measure_half("R1 half 5", 5);
        cfg_integ = 12'd150;
        measure_reset(150);
        check("R5 still legal", int'(cfg_err), 0);

        // Clock divider out of range
        cfg_half = 8'd0;
        measure_half("R1 clamp low", HALF_MIN);
        check("R5 err on half", int'(cfg_err), 1);
        cfg_half = 8'd9;
        measure_half("R1 clamp high", HALF_MAX);

        // Integration out of range, after a fresh reset
        cfg_half = 8'd2; cfg_integ = 12'd10;
        do_reset();
        check("R5 cleared by reset", int'(cfg_err), 0);
        @(negedge clk); cfg_integ = 12'd0;
        measure_reset(1);
        check("R5 err on integ", int'(cfg_err), 1);
        cfg_integ = 12'd999;
        measure_reset(INTEG_MAX);
        check("R2 reset edges on falls", r2_bad, 0);

        // Serial capture
        cfg_integ = 12'd1;
        do_reset();
        wait_fall();
        for (int i = 0; i < NPIX; i++) begin
            adc_a = DATA_W'(12'h100 + i); adc_b = 12'hAAA;
            pulse_trig(i < CHIP_PIX, i >= CHIP_PIX);
            check("R6 valid", int'(a_valid), 1);
            check("R6 data", int'(a_data), 12'h100 + i);
            check("R6 chan", int'(a_chan), i);
            check("R6 stream B idle", int'(b_valid), 0);
            if (i == 0) begin
                @(negedge clk);
                check("R8 held valid", int'(a_valid), 1);
                check("R8 held data", int'(a_data), 12'h100);
            end
            accept_both();
            check("R8 accepted", int'(a_valid), 0);
        end
        wait_fall();
        adc_a = 12'h077;
        pulse_trig(1'b1, 1'b0);
        check("R6 restart chan", int'(a_chan), 0);
        check("R9 no overrun yet", int'(overrun), 0);
        adc_a = 12'h055;
        pulse_trig(1'b1, 1'b0);
        check("R9 overrun set", int'(overrun), 1);
        check("R9 held word kept", int'(a_data), 12'h077);
        accept_both();
        adc_a = 12'h066;
        pulse_trig(1'b1, 1'b0);
        check("R9 dropped sample counted", int'(a_chan), 2);
        accept_both();
        check("R9 overrun sticky", int'(overrun), 1);

        // Serial end of scan and chaining
        @(negedge clk); eos_a_n = 1'b0; #1;
        check("R11 start follows eos", int'(chip_b_start), 0);
        eos_a_n = 1'b1;
        pulse_eos(1'b1, 1'b0, 0, "R10 serial first chip only");
        pulse_eos(1'b0, 1'b1, 1, "R10 serial last chip");

        // Parallel mode
        cfg_par = 1'b1;
        wait_fall();
        check("R11 master in parallel", int'(chip_b_master), 1);
        eos_a_n = 1'b0; #1;
        check("R11 start held high", int'(chip_b_start), 1);
        eos_a_n = 1'b1;
        for (int i = 0; i < 2; i++) begin
            adc_a = DATA_W'(12'h020 + i); adc_b = DATA_W'(12'h030 + i);
            pulse_trig(1'b1, 1'b1);
            check("R7 a data", int'(a_data), 12'h020 + i);
            check("R7 a chan", int'(a_chan), i);
            check("R7 b valid", int'(b_valid), 1);
            check("R7 b data", int'(b_data), 12'h030 + i);
            check("R7 b chan", int'(b_chan), CHIP_PIX + i);
            accept_both();
        end
        pulse_eos(1'b1, 1'b0, 0, "R10 parallel a only");
        pulse_eos(1'b0, 1'b1, 1, "R10 parallel a then b");
        pulse_eos(1'b0, 1'b1, 0, "R10 parallel b only");
        pulse_eos(1'b1, 1'b0, 1, "R10 parallel b then a");

        check("R2 reset edges on falls", r2_bad, 0);
        finish_run();
    end
endmodule